// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line interrupt controllers, a primary and a secondary, into one sixteen-line interrupt system. Each controller latches requests on rising input edges, hides masked lines, and resolves the pending line with the highest fixed priority (line 0 highest) against its in-service set. Whenever the secondary has a line it could deliver, that fact is fed into the primary as a request on the cascade line, line 2. The primary's own input 2 is therefore not used.

The processor sees one interrupt output. An acknowledge strobe walks the cascade: the primary is resolved first. If the primary picks the cascade line, the secondary is resolved and acknowledged. The vector and the 0..15 line number appear one clock later. When nothing can be resolved, line 7 of the controller concerned is reported as spurious. Software may also poll either controller, or issue a combined read that polls through the cascade. A combined read also switches the status view from the primary's pending set to its in-service set. Separate end-of-service strobes retire the highest-priority in-service line of each controller.

Top module: `cascade_ack_seq`

## Requirements
- R1: After reset, cpu_int, vec_valid and rd_valid are 0 and status_data shows the primary pending set, which is 0.
- R2: A line becomes pending on a rising edge of its input. A level held high does not raise it again after service. A masked line is not delivered, but its edge is kept and delivered once unmasked. Line 0 has the highest priority and line 7 the lowest. cpu_int is high while the primary resolves a pending line that ranks above its in-service lines.
- R3: An unmasked pending secondary line (inputs 8..15) ranking above the secondary's in-service lines raises primary line 2 and so cpu_int. Input 2 is ignored. Each secondary line ranks between primary lines 1 and 3.
- R4: vec_valid pulses high exactly one clock after ack_strobe. For a primary line L it shows vec_out = {m_base[7:3], L} and ack_line = L. L then moves from pending to in-service.
- R5: When the primary resolves line 2, the secondary's line S is acknowledged, with vec_out = {s_base[7:3], S} and ack_line = 8 + S.
- R6: If the secondary resolves nothing during a cascaded acknowledge, ack_line = 15 and vec_out = {s_base[7:3], 3'b111}.
- R7: If the primary resolves nothing, ack_line = 7 and vec_out = {m_base[7:3], 3'b111}, and no state changes.
- R8: A poll (poll_strobe, poll_slave selects the secondary) returns the resolved line number 0..7 on rd_data one clock later with rd_valid. It clears that line's pending and in-service bits. It returns 7 when nothing resolves.
- R9: A poll of the secondary that finds a line also clears primary line 2 pending and in-service, so cpu_int drops.
- R10: A combined read (combo_strobe) polls the primary. If the result is 2, it polls the secondary and returns 8 plus its result (15 when the secondary has none). From then on status_data shows the primary in-service set instead of the pending set.
- R11: eoi_master / eoi_slave clear the highest-priority in-service bit of that controller.
- R12: cpu_int is re-evaluated from the new state right after every acknowledge, and is 0 after a line is acknowledged when no other line outranks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Request inputs; 0..7 primary, 8..15 secondary |
| irq_mask | input | 16 | 1 masks the matching line |
| m_base | input | 8 | Primary vector base, low 3 bits ignored |
| s_base | input | 8 | Secondary vector base, low 3 bits ignored |
| ack_strobe | input | 1 | Interrupt acknowledge (highest strobe priority) |
| poll_strobe | input | 1 | Poll one controller (lowest strobe priority) |
| poll_slave | input | 1 | Poll target: 1 secondary, 0 primary |
| combo_strobe | input | 1 | Combined read through the cascade |
| eoi_master | input | 1 | End of service on the primary |
| eoi_slave | input | 1 | End of service on the secondary |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | vec_out/ack_line valid this cycle |
| vec_out | output | 8 | Acknowledge vector |
| ack_line | output | 4 | Acknowledged line number 0..15 |
| rd_valid | output | 1 | rd_data valid this cycle |
| rd_data | output | 4 | Poll or combined read result |
| status_data | output | 8 | Primary pending or in-service set |

## Verification
The acknowledge is swept over every usable line on its own, which separates primary vectors from cascaded ones and checks the 8 + S numbering. It is then swept over every ordered pair of lines, which exposes any error in where the cascade line sits in the priority order. Polls and combined reads are swept over every line and also tried with nothing pending, which tells the spurious 7 and 15 results apart from real ones. Masking a secondary line after it has been forwarded produces the cascaded spurious case, and a two-deep in-service stack shows which bit end of service removes.

// File: rtl/cac_pkg.sv
package cac_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_ACK,
    OP_COMBO,
    OP_POLL_M,
    OP_POLL_S
  } cac_op_e;
endpackage

// File: rtl/cac_resolver.sv
module cac_resolver #(
  parameter int LINES = 8,
  parameter int LW    = $clog2(LINES)
) (
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] insvc,
  output logic             valid,
  output logic [LW-1:0]    line
);
  logic          p_any, s_any;
  logic [LW-1:0] p_idx, s_idx;

  always_comb begin
    p_any = 1'b0;
    p_idx = '0;
    s_any = 1'b0;
    s_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        p_any = 1'b1;
        p_idx = LW'(i);
      end
      if (insvc[i]) begin
        s_any = 1'b1;
        s_idx = LW'(i);
      end
    end
    valid = p_any && (!s_any || (p_idx < s_idx));
    line  = p_idx;
  end

  // R2: a resolved line is always one that is pending
  always_comb begin
    if (valid) begin
      a_r2_pick_pending : assert (req[line]);
    end
  end
endmodule

// File: rtl/cac_lane.sv
module cac_lane #(
  parameter int LINES = 8,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] inject,
  input  logic [LINES-1:0] clr_req,
  input  logic [LINES-1:0] clr_isr,
  input  logic [LINES-1:0] set_isr,
  input  logic             eoi,
  output logic [LINES-1:0] irr,
  output logic [LINES-1:0] isr,
  output logic             valid,
  output logic [LW-1:0]    line
);
  logic [LINES-1:0] last_q, irr_q, isr_q;
  logic [LINES-1:0] irr_d, isr_d, eoi_clr;

  always_comb begin
    eoi_clr = eoi ? (isr_q & (~isr_q + LINES'(1))) : '0;
    irr_d   = (irr_q & ~clr_req) | (lines & ~last_q) | inject;
    isr_d   = (isr_q & ~clr_isr & ~eoi_clr) | set_isr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
    end else begin
      last_q <= lines;
      irr_q  <= irr_d;
      isr_q  <= isr_d;
    end
  end

  assign irr = irr_q;
  assign isr = isr_q;

  cac_resolver #(.LINES(LINES), .LW(LW)) u_res (
    .req   (irr_q & ~mask),
    .insvc (isr_q),
    .valid (valid),
    .line  (line)
  );

  // R11: end of service removes exactly one in-service bit
  a_r11_eoi_one_bit : assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_q != '0 && set_isr == '0 && clr_isr == '0)
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq #(
  parameter int LINES = 8,
  parameter int VW    = 8,
  parameter int CASC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LINES-1:0] irq_in,
  input  logic [2*LINES-1:0] irq_mask,
  input  logic [VW-1:0]      m_base,
  input  logic [VW-1:0]      s_base,
  input  logic               ack_strobe,
  input  logic               poll_strobe,
  input  logic               poll_slave,
  input  logic               combo_strobe,
  input  logic               eoi_master,
  input  logic               eoi_slave,
  output logic               cpu_int,
  output logic               vec_valid,
  output logic [VW-1:0]      vec_out,
  output logic [$clog2(LINES):0] ack_line,
  output logic               rd_valid,
  output logic [$clog2(LINES):0] rd_data,
  output logic [LINES-1:0]   status_data
);
  import cac_pkg::*;

  localparam int LW = $clog2(LINES);
  localparam logic [LW-1:0]    SPUR     = LW'(LINES - 1);
  localparam logic [LW-1:0]    CASC_IDX = LW'(CASC);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // lane 0 primary, lane 1 secondary
  logic [LINES-1:0] l_lines [2];
  logic [LINES-1:0] l_mask  [2];
  logic [LINES-1:0] l_inj   [2];
  logic [LINES-1:0] l_clr_req [2];
  logic [LINES-1:0] l_clr_isr [2];
  logic [LINES-1:0] l_set_isr [2];
  logic             l_eoi   [2];
  logic [LINES-1:0] l_irr   [2];
  logic [LINES-1:0] l_isr   [2];
  logic             l_valid [2];
  logic [LW-1:0]    l_line  [2];

  always_comb begin
    l_lines[0] = irq_in[LINES-1:0] & ~CASC_BIT;
    l_lines[1] = irq_in[2*LINES-1:LINES];
    l_mask[0]  = irq_mask[LINES-1:0];
    l_mask[1]  = irq_mask[2*LINES-1:LINES];
    l_eoi[0]   = eoi_master;
    l_eoi[1]   = eoi_slave;
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    cac_lane #(.LINES(LINES), .LW(LW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_q),
      .lines   (l_lines[g]),
      .mask    (l_mask[g]),
      .inject  (l_inj[g]),
      .clr_req (l_clr_req[g]),
      .clr_isr (l_clr_isr[g]),
      .set_isr (l_set_isr[g]),
      .eoi     (l_eoi[g]),
      .irr     (l_irr[g]),
      .isr     (l_isr[g]),
      .valid   (l_valid[g]),
      .line    (l_line[g])
    );
  end

  cac_op_e op;
  logic    casc_hit;
  logic [LINES-1:0] m_oh, s_oh;

  logic          vec_v_d, vec_v_q, rd_v_d, rd_v_q, sel_d, sel_q;
  logic [VW-1:0] vec_d, vec_q;
  logic [LW:0]   ln_d, ln_q, rd_d, rd_q;

  always_comb begin
    if (ack_strobe)                    op = OP_ACK;
    else if (combo_strobe)             op = OP_COMBO;
    else if (poll_strobe && poll_slave) op = OP_POLL_S;
    else if (poll_strobe)              op = OP_POLL_M;
    else                               op = OP_NONE;
  end

  always_comb begin
    casc_hit = l_valid[0] && (l_line[0] == CASC_IDX);
    m_oh     = LINES'(1) << l_line[0];
    s_oh     = LINES'(1) << l_line[1];
    for (int g = 0; g < 2; g++) begin
      l_clr_req[g] = '0;
      l_clr_isr[g] = '0;
      l_set_isr[g] = '0;
    end
    l_inj[0] = (l_valid[1] && op == OP_NONE) ? CASC_BIT : '0;
    l_inj[1] = '0;
    vec_v_d  = 1'b0;
    vec_d    = vec_q;
    ln_d     = ln_q;
    rd_v_d   = 1'b0;
    rd_d     = rd_q;
    sel_d    = sel_q;
    unique case (op)
      OP_ACK: begin
        vec_v_d = 1'b1;
        if (!l_valid[0]) begin
          vec_d = {m_base[VW-1:LW], SPUR};
          ln_d  = {1'b0, SPUR};
        end else begin
          l_set_isr[0] = m_oh;
          l_clr_req[0] = m_oh;
          if (!casc_hit) begin
            vec_d = {m_base[VW-1:LW], l_line[0]};
            ln_d  = {1'b0, l_line[0]};
          end else if (l_valid[1]) begin
            l_set_isr[1] = s_oh;
            l_clr_req[1] = s_oh;
            vec_d = {s_base[VW-1:LW], l_line[1]};
            ln_d  = {1'b1, l_line[1]};
          end else begin
            vec_d = {s_base[VW-1:LW], SPUR};
            ln_d  = {1'b1, SPUR};
          end
        end
      end
      OP_POLL_M, OP_COMBO: begin
        rd_v_d = 1'b1;
        rd_d   = {1'b0, l_valid[0] ? l_line[0] : SPUR};
        if (l_valid[0]) begin
          l_clr_req[0] = m_oh;
          l_clr_isr[0] = m_oh;
        end
        if (op == OP_COMBO) begin
          sel_d = 1'b1;
          if (casc_hit) begin
            rd_d = {1'b1, l_valid[1] ? l_line[1] : SPUR};
            if (l_valid[1]) begin
              l_clr_req[1] = s_oh;
              l_clr_isr[1] = s_oh;
            end
          end
        end
      end
      OP_POLL_S: begin
        rd_v_d = 1'b1;
        rd_d   = {1'b0, l_valid[1] ? l_line[1] : SPUR};
        if (l_valid[1]) begin
          l_clr_req[1] = s_oh;
          l_clr_isr[1] = s_oh;
          l_clr_req[0] = CASC_BIT;
          l_clr_isr[0] = CASC_BIT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vec_v_q <= 1'b0;
      vec_q   <= '0;
      ln_q    <= '0;
      rd_v_q  <= 1'b0;
      rd_q    <= '0;
      sel_q   <= 1'b0;
    end else begin
      vec_v_q <= vec_v_d;
      vec_q   <= vec_d;
      ln_q    <= ln_d;
      rd_v_q  <= rd_v_d;
      rd_q    <= rd_d;
      sel_q   <= sel_d;
    end
  end

  assign cpu_int     = l_valid[0];
  assign vec_valid   = vec_v_q;
  assign vec_out     = vec_q;
  assign ack_line    = ln_q;
  assign rd_valid    = rd_v_q;
  assign rd_data     = rd_q;
  assign status_data = sel_q ? l_isr[0] : l_irr[0];

  // R4: vector valid exactly one clock after the acknowledge
  a_r4_vec_next : assert property (@(posedge clk) disable iff (!rst_q)
    ack_strobe |=> vec_valid);
  a_r4_vec_only : assert property (@(posedge clk) disable iff (!rst_q)
    !ack_strobe |=> !vec_valid);
  // R7: nothing on the primary gives spurious line 7
  a_r7_spurious : assert property (@(posedge clk) disable iff (!rst_q)
    (ack_strobe && !l_valid[0]) |=> (ack_line == {1'b0, SPUR} && vec_out[LW-1:0] == SPUR));
  // R3: a deliverable secondary line reaches the cascade line
  a_r3_inject : assert property (@(posedge clk) disable iff (!rst_q)
    (l_valid[1] && op == OP_NONE) |=> l_irr[0][CASC]);
  // R10: combined read switches the status view
  a_r10_sel : assert property (@(posedge clk) disable iff (!rst_q)
    combo_strobe |=> (status_data == l_isr[0]));
  // R8: empty primary poll returns 7
  a_r8_poll_empty : assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_POLL_M && !l_valid[0]) |=> (rd_valid && rd_data == {1'b0, SPUR}));
  // R12: the processor line implies an unmasked pending primary line
  a_r12_cpu_pending : assert property (@(posedge clk) disable iff (!rst_q)
    cpu_int |-> ((l_irr[0] & ~l_mask[0]) != '0));
endmodule

// File: tb/tb_cascade_ack_seq.sv
module tb_cascade_ack_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq, msk;
  logic [7:0]  mb, sb;
  logic        ack, poll, pslv, combo, eoim, eois;
  logic        cpu_int, vec_valid, rd_valid;
  logic [7:0]  vec_out, status_data;
  logic [3:0]  ack_line, rd_data;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cascade_ack_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .irq_mask(msk),
    .m_base(mb), .s_base(sb), .ack_strobe(ack), .poll_strobe(poll),
    .poll_slave(pslv), .combo_strobe(combo), .eoi_master(eoim),
    .eoi_slave(eois), .cpu_int(cpu_int), .vec_valid(vec_valid),
    .vec_out(vec_out), .ack_line(ack_line), .rd_valid(rd_valid),
    .rd_data(rd_data), .status_data(status_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int vexp(input int l);
    return (l < 8) ? ((mb & 8'hF8) | l) : ((sb & 8'hF8) | (l - 8));
  endfunction

  function automatic int rank(input int l);
    return (l < 8) ? l * 8 : 16 + (l - 8);
  endfunction

  task automatic do_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic do_eoi(input int l);
    eoim = 1'b1; eois = (l >= 8); cyc(1); eoim = 1'b0; eois = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq = '0; msk = '0; mb = 8'h45; sb = 8'h73;
    ack = 0; poll = 0; pslv = 0; combo = 0; eoim = 0; eois = 0;
    cyc(3); rst_n = 1'b1; cyc(4);
    chk("R1 cpu_int", cpu_int, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 status", status_data, 0);

    // R3: input 2 ignored
    irq[2] = 1'b1; cyc(3);
    chk("R3 input2 ignored", cpu_int, 0);
    irq[2] = 1'b0; cyc(2);

    // single-line acknowledge sweep
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      irq[l] = 1'b1; cyc(3);
      chk(l < 8 ? "R2 cpu_int raised" : "R3 cascade raised", cpu_int, 1);
      do_ack();
      chk("R4 vec_valid", vec_valid, 1);
      chk(l < 8 ? "R4 vector" : "R5 vector", vec_out, vexp(l));
      chk(l < 8 ? "R4 line" : "R5 line", ack_line, l);
      chk("R12 cpu_int after ack", cpu_int, 0);
      cyc(1);
      chk("R4 vec_valid one cycle", vec_valid, 0);
      do_eoi(l); cyc(2);
      chk("R2 held level no retrigger", cpu_int, 0);
      irq[l] = 1'b0; cyc(2);
    end

    // priority over every pair
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        if (a == 2 || b == 2) continue;
        begin
          int f, s;
          f = (rank(a) < rank(b)) ? a : b;
          s = (f == a) ? b : a;
          irq[a] = 1'b1; irq[b] = 1'b1; cyc(3);
          do_ack();
          chk("R2 R3 pair first", ack_line, f);
          do_eoi(f); cyc(3);
          do_ack();
          chk("R2 R3 pair second", ack_line, s);
          do_eoi(s);
          irq[a] = 1'b0; irq[b] = 1'b0; cyc(2);
        end
      end
    end

    // mask holds a latched edge
    msk[5] = 1'b1; irq[5] = 1'b1; cyc(3);
    chk("R2 masked", cpu_int, 0);
    msk[5] = 1'b0; cyc(1);
    chk("R2 unmasked", cpu_int, 1);
    do_ack(); chk("R2 unmasked line", ack_line, 5);
    do_eoi(5); irq[5] = 1'b0; cyc(2);

    // R7 spurious primary
    do_ack();
    chk("R7 line", ack_line, 7);
    chk("R7 vector", vec_out, (mb & 8'hF8) | 7);
    chk("R7 cpu_int", cpu_int, 0);

    // R6 spurious secondary
    irq[12] = 1'b1; cyc(3);
    msk[12] = 1'b1; cyc(1);
    do_ack();
    chk("R6 line", ack_line, 15);
    chk("R6 vector", vec_out, (sb & 8'hF8) | 7);
    do_eoi(0); msk[12] = 1'b0; cyc(3);
    do_ack(); chk("R6 later real", ack_line, 12);
    do_eoi(12); irq[12] = 1'b0; cyc(2);

    // poll sweep
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      irq[l] = 1'b1; cyc(3);
      poll = 1'b1; pslv = (l >= 8); cyc(1); poll = 1'b0; pslv = 1'b0;
      chk("R8 rd_valid", rd_valid, 1);
      chk("R8 poll line", rd_data, l & 7);
      chk(l < 8 ? "R8 poll retires" : "R9 cascade retired", cpu_int, 0);
      irq[l] = 1'b0; cyc(2);
    end
    poll = 1'b1; cyc(1); poll = 1'b0;
    chk("R8 empty primary poll", rd_data, 7);
    poll = 1'b1; pslv = 1'b1; cyc(1); poll = 1'b0; pslv = 1'b0;
    chk("R8 empty secondary poll", rd_data, 7);

    // combined read
    irq[5] = 1'b1; cyc(3);
    chk("R10 status pending view", status_data, 8'h20);
    combo = 1'b1; cyc(1); combo = 1'b0;
    chk("R10 combined primary", rd_data, 5);
    chk("R10 status in-service view", status_data, 0);
    irq[5] = 1'b0; cyc(2);
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      irq[l] = 1'b1; cyc(3);
      combo = 1'b1; cyc(1); combo = 1'b0;
      chk("R10 combined line", rd_data, l);
      chk("R10 combined retires", cpu_int, 0);
      irq[l] = 1'b0; cyc(2);
    end
    combo = 1'b1; cyc(1); combo = 1'b0;
    chk("R10 combined empty", rd_data, 7);
    irq[11] = 1'b1; cyc(3); msk[11] = 1'b1; cyc(1);
    combo = 1'b1; cyc(1); combo = 1'b0;
    chk("R10 combined secondary spurious", rd_data, 15);
    irq[11] = 1'b0; cyc(1); msk[11] = 1'b0;
    poll = 1'b1; pslv = 1'b1; cyc(1); poll = 1'b0; pslv = 1'b0; cyc(2);

    // R11 end of service order
    irq[3] = 1'b1; cyc(3); do_ack();
    irq[1] = 1'b1; cyc(3); do_ack();
    chk("R11 stack", status_data, 8'h0A);
    eoim = 1'b1; cyc(1); eoim = 1'b0;
    chk("R11 highest cleared", status_data, 8'h08);
    eoim = 1'b1; cyc(1); eoim = 1'b0;
    chk("R11 last cleared", status_data, 0);
    irq = '0; cyc(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule